// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Holdoff

This block merges three groups of interrupt sources into one active-low interrupt pin. The first group is a set of general network events. The second is one summary bit per socket. The third reports completion or timeout of commands that run without a socket. The general and socketless groups latch single-cycle event pulses into status registers. Software clears those registers by writing ones to dedicated clear addresses. The socket group is not latched. Each bit mirrors, one clock later, whether any interrupt flag of that socket is set, so it drops by itself once the socket's own flags are cleared.

Every group has an enable mask. The pin goes low when a status bit and its mask bit are both set, provided the global enable is on. A holdoff timer keeps the pin quiet after service. The timer starts when the pin releases because everything pending was cleared. It loads a programmable 16-bit value and counts down by one every fourth clock. The pin may assert again only after the count reaches zero.

The host reaches the registers through a plain write strobe and a combinational read port. There is no data stream and no back-pressure. A write completes in the cycle its strobe is high. A read returns the addressed register in the same cycle.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status, mask, holdoff and control register reads 0 and `irq_n` is high.
- R2: A pulse on `comm_evt` sets general status bits 7, 4, 2, 1 and 0 on the next clock. Bits 6, 5 and 3 are reserved and always read 0.
- R3: A pulse on any bit of `sl_evt` sets the same socketless status bit on the next clock. All eight bits are used (7 timeout, 6..0 command completions).
- R4: Writing ones to the general clear address (6) or the socketless clear address (7) clears those status bits. An event arriving in the same cycle as the clear keeps its bit set.
- R5: Socket status bit N equals, one clock later, the OR of the 8 flag bits `sock_flags[8N+7:8N]`. Host writes to the socket status address change nothing.
- R6: `irq_n` is low only when the global enable is set, some status bit and its mask bit are both set, and the holdoff counter is zero. A status bit whose mask bit is clear never drives the pin.
- R7: With the global enable bit (address 10, bit 0) clear, `irq_n` stays high whatever is pending.
- R8: The holdoff counter starts when `irq_n` was low in the previous cycle and nothing enabled is pending. It loads the holdoff register, drops by one every 4 clocks, and keeps `irq_n` high while nonzero.
- R9: Read map: 0 general status, 1 socket status, 2 socketless status, 3/4/5 the three masks in that order, 8/9 holdoff low/high byte, 10 control. Clear addresses and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comm_evt | input | 8 | General event pulses, one per status bit |
| sl_evt | input | 8 | Socketless command event pulses |
| sock_flags | input | 64 | Per-socket interrupt flag levels, 8 per socket |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data, combinational |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The general group gets an all-ones pulse, which shows that the reserved positions stay dark. It then gets a single unmasked bit, which must leave the pin alone. The socketless group is driven with a clear and an event in the same cycle, which shows whether the event or the clear wins. Socket flags are set one bit at a time on different sockets and then removed, which separates a true OR-follow from a latched copy. The pin is tested with the global enable off and then on. It is also re-triggered inside a running holdoff window, which shows whether the countdown really gates re-assertion and starts only after a release.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [3:0] {
    RA_COMM_ST  = 4'd0,
    RA_SOCK_ST  = 4'd1,
    RA_SL_ST    = 4'd2,
    RA_COMM_MSK = 4'd3,
    RA_SOCK_MSK = 4'd4,
    RA_SL_MSK   = 4'd5,
    RA_COMM_CLR = 4'd6,
    RA_SL_CLR   = 4'd7,
    RA_HOLD_LO  = 4'd8,
    RA_HOLD_HI  = 4'd9,
    RA_CTRL     = 4'd10
  } reg_addr_e;

  localparam int          ADDR_W     = 4;
  localparam logic [7:0]  COMM_VALID = 8'h97;
  localparam logic [7:0]  SL_VALID   = 8'hFF;
endpackage

// File: rtl/irq_status_group.sv
module irq_status_group #(
  parameter int         W     = 8,
  parameter logic [7:0] VALID = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  localparam logic [W-1:0] KEEP = W'(VALID);

  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | (evt & KEEP);
  end

  assign stat = stat_q;
endmodule

// File: rtl/irq_sock_status.sv
module irq_sock_status #(
  parameter int SOCK_N = 8,
  parameter int FLAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SOCK_N*FLAG_W-1:0] flags,
  output logic [SOCK_N-1:0]        stat
);
  logic [SOCK_N-1:0] any_set;
  logic [SOCK_N-1:0] stat_q;

  for (genvar s = 0; s < SOCK_N; s++) begin : g_sock
    assign any_set[s] = |flags[s*FLAG_W +: FLAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= any_set;
  end

  assign stat = stat_q;
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int HOLD_W   = 16,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              gie,
  input  logic [HOLD_W-1:0] reload_val,
  output logic              irq_n,
  output logic [HOLD_W-1:0] cnt,
  output logic              armed
);
  logic [HOLD_W-1:0] cnt_q;
  logic              act_q;
  logic              active;
  logic              reload;
  logic              running;
  logic              tick;

  assign running = (cnt_q != '0);
  assign active  = gie & pending & ~running;
  assign reload  = act_q & ~pending;

  if (PRESCALE <= 1) begin : g_nodiv
    assign tick = 1'b1;
  end else begin : g_div
    localparam int DIV_W = $clog2(PRESCALE);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (reload || !running || tick) div_q <= '0;
      else                       div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= active;
      if (reload)               cnt_q <= reload_val;
      else if (running && tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_n = ~active;
  assign cnt   = cnt_q;
  assign armed = act_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int DW       = 8,
  parameter int SOCK_N   = 8,
  parameter int FLAG_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            comm_evt,
  input  logic [DW-1:0]            sl_evt,
  input  logic [SOCK_N*FLAG_W-1:0] sock_flags,
  input  logic                     wr_en,
  input  logic [3:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [3:0]               rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     irq_n
);
  import irq_pkg::*;

  localparam int HOLD_W = 2 * DW;

  logic [DW-1:0]     comm_st, sl_st;
  logic [SOCK_N-1:0] sock_st;
  logic [DW-1:0]     comm_msk_q, sl_msk_q;
  logic [SOCK_N-1:0] sock_msk_q;
  logic [HOLD_W-1:0] hold_q;
  logic              gie_q;
  logic [DW-1:0]     comm_clr, sl_clr;
  logic              pending;
  logic [HOLD_W-1:0] hold_cnt;
  logic              armed;
  logic [DW-1:0]     sock_st_ext;

  assign comm_clr = (wr_en && wr_addr == RA_COMM_CLR) ? wr_data : '0;
  assign sl_clr   = (wr_en && wr_addr == RA_SL_CLR)   ? wr_data : '0;

  irq_status_group #(.W(DW), .VALID(COMM_VALID)) u_comm (
    .clk(clk), .rst_n(rst_n), .evt(comm_evt), .clr(comm_clr), .stat(comm_st)
  );

  irq_status_group #(.W(DW), .VALID(SL_VALID)) u_sl (
    .clk(clk), .rst_n(rst_n), .evt(sl_evt), .clr(sl_clr), .stat(sl_st)
  );

  irq_sock_status #(.SOCK_N(SOCK_N), .FLAG_W(FLAG_W)) u_sock (
    .clk(clk), .rst_n(rst_n), .flags(sock_flags), .stat(sock_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comm_msk_q <= '0;
      sock_msk_q <= '0;
      sl_msk_q   <= '0;
      hold_q     <= '0;
      gie_q      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_COMM_MSK: comm_msk_q <= wr_data;
        RA_SOCK_MSK: sock_msk_q <= wr_data[SOCK_N-1:0];
        RA_SL_MSK:   sl_msk_q   <= wr_data;
        RA_HOLD_LO:  hold_q[DW-1:0]      <= wr_data;
        RA_HOLD_HI:  hold_q[HOLD_W-1:DW] <= wr_data;
        RA_CTRL:     gie_q      <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign pending = (|(comm_st & comm_msk_q)) | (|(sock_st & sock_msk_q)) |
                   (|(sl_st & sl_msk_q));

  irq_holdoff #(.HOLD_W(HOLD_W), .PRESCALE(PRESCALE)) u_hold (
    .clk(clk), .rst_n(rst_n), .pending(pending), .gie(gie_q),
    .reload_val(hold_q), .irq_n(irq_n), .cnt(hold_cnt), .armed(armed)
  );

  always_comb begin
    sock_st_ext = '0;
    sock_st_ext[SOCK_N-1:0] = sock_st;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_COMM_ST:  rd_data = comm_st;
      RA_SOCK_ST:  rd_data = sock_st_ext;
      RA_SL_ST:    rd_data = sl_st;
      RA_COMM_MSK: rd_data = comm_msk_q;
      RA_SOCK_MSK: rd_data[SOCK_N-1:0] = sock_msk_q;
      RA_SL_MSK:   rd_data = sl_msk_q;
      RA_HOLD_LO:  rd_data = hold_q[DW-1:0];
      RA_HOLD_HI:  rd_data = hold_q[HOLD_W-1:DW];
      RA_CTRL:     rd_data[0] = gie_q;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int DW     = 8,
  parameter int SOCK_N = 8,
  parameter int FLAG_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DW-1:0]            comm_evt,
  input logic [DW-1:0]            sl_evt,
  input logic [SOCK_N*FLAG_W-1:0] sock_flags,
  input logic                     wr_en,
  input logic [3:0]               wr_addr,
  input logic [DW-1:0]            wr_data,
  input logic [DW-1:0]            comm_st,
  input logic [DW-1:0]            sl_st,
  input logic [SOCK_N-1:0]        sock_st,
  input logic                     gie_q,
  input logic                     pending,
  input logic                     armed,
  input logic [2*DW-1:0]          hold_cnt,
  input logic [2*DW-1:0]          hold_q,
  input logic                     irq_n
);
  assert_comm_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    comm_evt[0] |=> comm_st[0]);

  assert_sl_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sl_evt[DW-1] |=> sl_st[DW-1]);

  assert_evt_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd7 && wr_data[0] && sl_evt[0]) |=> sl_st[0]);

  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd7 && wr_data[1] && !sl_evt[1]) |=> !sl_st[1]);

  for (genvar s = 0; s < SOCK_N; s++) begin : g_sk
    assert_sock_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sock_st[s] == $past(|sock_flags[s*FLAG_W +: FLAG_W])));
  end

  assert_pin_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> pending);

  assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> irq_n);

  assert_holdoff_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |-> irq_n);

  assert_holdoff_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !pending) |=> (hold_cnt == $past(hold_q)));
endmodule

bind irq_aggregator irq_aggregator_chk #(.DW(DW), .SOCK_N(SOCK_N), .FLAG_W(FLAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .comm_evt(comm_evt), .sl_evt(sl_evt),
  .sock_flags(sock_flags), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .comm_st(comm_st), .sl_st(sl_st), .sock_st(sock_st), .gie_q(gie_q),
  .pending(pending), .armed(armed), .hold_cnt(hold_cnt), .hold_q(hold_q),
  .irq_n(irq_n)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  comm_evt = '0, sl_evt = '0;
  logic [63:0] sock_flags = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .comm_evt(comm_evt), .sl_evt(sl_evt),
    .sock_flags(sock_flags), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural reference state
  logic [7:0] m_cs, m_ss, m_ls, m_cm, m_sm, m_lm;
  bit         m_gie, m_act;
  int         m_hold, m_cnt, m_div;

  function automatic bit m_pend();
    return ((m_cs & m_cm) != 0) || ((m_ss & m_sm) != 0) || ((m_ls & m_lm) != 0);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_cs;
      4'd1: return m_ss;
      4'd2: return m_ls;
      4'd3: return m_cm;
      4'd4: return m_sm;
      4'd5: return m_lm;
      4'd8: return m_hold[7:0];
      4'd9: return m_hold[15:8];
      4'd10: return {7'd0, m_gie};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 0; m_ss = 0; m_ls = 0; m_cm = 0; m_sm = 0; m_lm = 0;
      m_gie = 0; m_act = 0; m_hold = 0; m_cnt = 0; m_div = 0;
    end else begin
      bit p, a;
      logic [7:0] cc, lc, ns;
      p = m_pend();
      a = m_gie && p && (m_cnt == 0);
      if (m_act && !p) begin m_cnt = m_hold; m_div = 0; end
      else if (m_cnt != 0) begin
        if (m_div == 3) begin m_cnt = m_cnt - 1; m_div = 0; end
        else m_div = m_div + 1;
      end else m_div = 0;
      m_act = a;
      cc = (wr_en && wr_addr == 4'd6) ? wr_data : 8'd0;
      lc = (wr_en && wr_addr == 4'd7) ? wr_data : 8'd0;
      m_cs = (m_cs & ~cc) | (comm_evt & 8'b1001_0111);
      m_ls = (m_ls & ~lc) | sl_evt;
      ns = 0;
      for (int s = 0; s < 8; s++) ns[s] = (sock_flags[s*8 +: 8] != 0);
      m_ss = ns;
      if (wr_en) begin
        case (wr_addr)
          4'd3: m_cm = wr_data;
          4'd4: m_sm = wr_data;
          4'd5: m_lm = wr_data;
          4'd8: m_hold = (m_hold & 32'hFF00) | wr_data;
          4'd9: m_hold = (m_hold & 32'h00FF) | (int'(wr_data) << 8);
          4'd10: m_gie = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    if (rst_n && !done) begin
      bit exp_n;
      #1;
      exp_n = !(m_gie && m_pend() && m_cnt == 0);
      chk(irq_n == exp_n, "R6 pin vs model", irq_n, exp_n);
      chk(rd_data == m_read(rd_addr), "R9 read vs model", rd_data, m_read(rd_addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_comm(input logic [7:0] v);
    @(negedge clk); comm_evt = v;
    @(negedge clk); comm_evt = 0;
  endtask

  task automatic pulse_sl(input logic [7:0] v);
    @(negedge clk); sl_evt = v;
    @(negedge clk); sl_evt = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=complete");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a <= 10; a++) rd_chk(4'(a), 8'h00, "R1 reset value");
    chk(irq_n == 1'b1, "R1 pin idle", irq_n, 1);

    // R2 general events, reserved bits stay clear; R6 pin asserts
    wr(4'd10, 8'h01);
    wr(4'd3, 8'h01);
    pulse_comm(8'hFF);
    rd_chk(4'd0, 8'h97, "R2 general status");
    chk(irq_n == 1'b0, "R6 pin low on enabled pending", irq_n, 0);

    // R8 holdoff after service
    wr(4'd8, 8'h03);
    rd_chk(4'd8, 8'h03, "R9 holdoff low byte");
    wr(4'd6, 8'hFF);
    rd_chk(4'd0, 8'h00, "R4 general clear");
    pulse_comm(8'h01);
    chk(irq_n == 1'b1, "R8 pin held during holdoff", irq_n, 1);
    idle(16);
    chk(irq_n == 1'b0, "R8 pin after holdoff expiry", irq_n, 0);

    // R6 masked bit does not drive the pin
    wr(4'd6, 8'hFF);
    idle(16);
    pulse_comm(8'h02);
    idle(4);
    rd_chk(4'd0, 8'h02, "R2 unmasked bit latched");
    chk(irq_n == 1'b1, "R6 masked bit ignored", irq_n, 1);

    // R7 global enable gating
    wr(4'd10, 8'h00);
    pulse_comm(8'h01);
    idle(4);
    chk(irq_n == 1'b1, "R7 pin blocked by global enable", irq_n, 1);
    wr(4'd10, 8'h01);
    #1 chk(irq_n == 1'b0, "R7 pin after enable", irq_n, 0);
    wr(4'd6, 8'hFF);
    idle(16);

    // R3 socketless events; R4 event beats clear
    wr(4'd5, 8'h80);
    pulse_sl(8'hFF);
    rd_chk(4'd2, 8'hFF, "R3 socketless status");
    @(negedge clk); wr_en = 1; wr_addr = 4'd7; wr_data = 8'h0F; sl_evt = 8'h01;
    @(negedge clk); wr_en = 0; sl_evt = 0;
    rd_chk(4'd2, 8'hF1, "R4 event wins over clear");
    wr(4'd7, 8'hFF);
    rd_chk(4'd2, 8'h00, "R4 socketless clear");
    idle(16);

    // R5 socket status follows flags
    @(negedge clk); sock_flags[2*8+5] = 1'b1;
    rd_chk(4'd1, 8'h04, "R5 socket 2 set");
    wr(4'd1, 8'hFF);
    rd_chk(4'd1, 8'h04, "R5 write to socket status ignored");
    @(negedge clk); sock_flags[7*8+0] = 1'b1; sock_flags[0*8+7] = 1'b1; sock_flags[2*8+5] = 1'b0;
    rd_chk(4'd1, 8'h81, "R5 sockets 7 and 0");
    wr(4'd4, 8'h80);
    idle(2);
    chk(irq_n == 1'b0, "R6 socket bit drives pin", irq_n, 0);
    @(negedge clk); sock_flags = '0;
    rd_chk(4'd1, 8'h00, "R5 self clear");
    idle(2);
    chk(irq_n == 1'b1, "R6 pin released", irq_n, 1);
    rd_chk(4'd10, 8'h01, "R9 control readback");
    rd_chk(4'd6, 8'h00, "R9 clear address reads 0");

    idle(4);
    done = 1;
    finish_up();
  end
endmodule